// File: doc/BRIEF.md
# Audio Controller Interrupt Aggregator

This block gathers every interrupt source of a multi-stream audio controller into one 32-bit composite status word and one level-sensitive interrupt line. The sources are the command-response ring (its status and control bits), the codec state-change flags with their wake-enable mask, and a status/control field pair for each of a parameterised number of input and output streams. The composite word and the line are recomputed from the present inputs and registered on every clock. The registers that hold the sources, including their write-one-to-clear logic, live outside the block.

The line is owned by a two-state machine. `LINE_IDLE` means the line is low and `LINE_RAISED` means it is high. On each clock the machine takes `IDLE->RAISED` or stays in `RAISED` when the global enable is set and at least one enabled controller or stream bit is pending. Otherwise it takes `RAISED->IDLE` or stays in `IDLE`. The global status bit can read 1 with every enable cleared. It is a summary only and never drives the line.

A constant vector reports the direction of each stream. Input streams take the lowest indices and output streams follow them.

Top module: `aic_irq_agg`

## Requirements
- R1: The controller bit (int_sts bit 30) is set when `ring_sts & ring_ctl` has bit 0 (response interrupt) or bit 1 (overrun interrupt) set.
- R2: The controller bit (int_sts bit 30) is also set when `codec_chg & codec_wake` is nonzero. It is clear when neither R1 nor R2 applies.
- R3: Stream n has a 3-bit field at bits [3n+2:3n] of `strm_sts` and `strm_ctl`. Bit 0 is completion, bit 1 is FIFO error and bit 2 is descriptor error. int_sts bit n is set when the AND of that stream's status and control fields is nonzero. int_sts bits 29 down to the stream count read 0.
- R4: int_sts bit 31 (global status) is set exactly when any of int_sts bits 30..0 is set.
- R5: `irq` is high when int_ctl bit 31 (global enable) is set and `int_sts & int_ctl` is nonzero over bits 30..0. Bit 30 is the controller enable and bit n is the enable for stream n. Otherwise `irq` is low.
- R6: The global status bit alone never raises `irq`. With int_ctl bits 30..0 all zero, `irq` stays low while int_sts bit 31 reads 1.
- R7: `strm_is_in[n]` is 1 for n below NUM_IN and 0 for the output streams above them.
- R8: `int_sts` and `irq` reflect the inputs sampled at the previous rising clock edge.
- R9: While `rst_n` is low, `int_sts` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_sts | input | 2 | Response-ring status: bit 0 response, bit 1 overrun |
| ring_ctl | input | 2 | Response-ring interrupt controls, same bit order |
| codec_chg | input | NUM_CODEC | Codec state-change flags |
| codec_wake | input | NUM_CODEC | Wake-enable mask for the codec flags |
| strm_sts | input | 3*(NUM_IN+NUM_OUT) | Per-stream status fields |
| strm_ctl | input | 3*(NUM_IN+NUM_OUT) | Per-stream interrupt enable fields |
| int_ctl | input | 32 | Global enable (31), controller enable (30), stream enables |
| int_sts | output | 32 | Registered composite interrupt status |
| irq | output | 1 | Registered level interrupt line |
| strm_is_in | output | NUM_IN+NUM_OUT | 1 marks an input stream |

## Verification
The bound checker compares on every cycle the controller bit, the stream bits, the global summary bit and the line level against a model registered from the inputs of the previous edge. It also checks that a pending status with no enable never raises the line. Only the bench scenarios show the reset values and the constant direction map. They also show that each source, driven alone, lands on its own status bit and raises the line only when its enable is set.

// File: rtl/aic_pkg.sv
package aic_pkg;
    localparam int STS_W      = 32;
    localparam int GLOBAL_BIT = 31;
    localparam int CTRL_BIT   = 30;
    localparam int FIELD_W    = 3;
    localparam int RING_W     = 2;

    typedef enum logic {
        LINE_IDLE   = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;
endpackage

// File: rtl/aic_ctrl_src.sv
module aic_ctrl_src
    import aic_pkg::*;
#(
    parameter int NUM_CODEC = 4
) (
    input  logic [RING_W-1:0]    ring_sts,
    input  logic [RING_W-1:0]    ring_ctl,
    input  logic [NUM_CODEC-1:0] codec_chg,
    input  logic [NUM_CODEC-1:0] codec_wake,
    output logic                 ctrl_hit
);
    logic ring_hit;
    logic codec_hit;

    always_comb begin
        ring_hit  = |(ring_sts & ring_ctl);
        codec_hit = |(codec_chg & codec_wake);
        ctrl_hit  = ring_hit | codec_hit;
    end
endmodule

// File: rtl/aic_stream_src.sv
module aic_stream_src
    import aic_pkg::*;
#(
    parameter int NUM_STR = 8
) (
    input  logic [NUM_STR*FIELD_W-1:0] strm_sts,
    input  logic [NUM_STR*FIELD_W-1:0] strm_ctl,
    output logic [NUM_STR-1:0]         strm_hit
);
    for (genvar n = 0; n < NUM_STR; n++) begin : g_str
        assign strm_hit[n] = |(strm_sts[n*FIELD_W +: FIELD_W] & strm_ctl[n*FIELD_W +: FIELD_W]);
    end
endmodule

// File: rtl/aic_line_fsm.sv
module aic_line_fsm
    import aic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STS_W-1:0] sts_next,
    input  logic [STS_W-1:0] int_ctl,
    output logic [STS_W-1:0] sts_q,
    output logic             line
);
    line_state_e state_q;
    line_state_e state_d;
    logic        want;

    always_comb begin
        want = int_ctl[GLOBAL_BIT] && (|(sts_next[CTRL_BIT:0] & int_ctl[CTRL_BIT:0]));
        state_d = state_q;
        unique case (state_q)
            LINE_IDLE:   if (want)  state_d = LINE_RAISED;
            LINE_RAISED: if (!want) state_d = LINE_IDLE;
            default:                state_d = LINE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_IDLE;
            sts_q   <= '0;
        end else begin
            state_q <= state_d;
            sts_q   <= sts_next;
        end
    end

    always_comb begin
        line = (state_q == LINE_RAISED);
    end
endmodule

// File: rtl/aic_irq_agg.sv
module aic_irq_agg
    import aic_pkg::*;
#(
    parameter int NUM_IN    = 4,
    parameter int NUM_OUT   = 4,
    parameter int NUM_CODEC = 4,
    localparam int NUM_STR  = NUM_IN + NUM_OUT,
    localparam int FLD_ALL  = NUM_STR * FIELD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [RING_W-1:0]    ring_sts,
    input  logic [RING_W-1:0]    ring_ctl,
    input  logic [NUM_CODEC-1:0] codec_chg,
    input  logic [NUM_CODEC-1:0] codec_wake,
    input  logic [FLD_ALL-1:0]   strm_sts,
    input  logic [FLD_ALL-1:0]   strm_ctl,
    input  logic [STS_W-1:0]     int_ctl,
    output logic [STS_W-1:0]     int_sts,
    output logic                 irq,
    output logic [NUM_STR-1:0]   strm_is_in
);
    logic               ctrl_hit;
    logic [NUM_STR-1:0] strm_hit;
    logic [STS_W-1:0]   sts_next;

    aic_ctrl_src #(.NUM_CODEC(NUM_CODEC)) u_ctrl (
        .ring_sts   (ring_sts),
        .ring_ctl   (ring_ctl),
        .codec_chg  (codec_chg),
        .codec_wake (codec_wake),
        .ctrl_hit   (ctrl_hit)
    );

    aic_stream_src #(.NUM_STR(NUM_STR)) u_str (
        .strm_sts (strm_sts),
        .strm_ctl (strm_ctl),
        .strm_hit (strm_hit)
    );

    always_comb begin
        sts_next                = '0;
        sts_next[NUM_STR-1:0]   = strm_hit;
        sts_next[CTRL_BIT]      = ctrl_hit;
        sts_next[GLOBAL_BIT]    = ctrl_hit | (|strm_hit);
    end

    aic_line_fsm u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .sts_next (sts_next),
        .int_ctl  (int_ctl),
        .sts_q    (int_sts),
        .line     (irq)
    );

    for (genvar n = 0; n < NUM_STR; n++) begin : g_dir
        if (n < NUM_IN) begin : g_in
            assign strm_is_in[n] = 1'b1;
        end else begin : g_out
            assign strm_is_in[n] = 1'b0;
        end
    end
endmodule

// File: rtl/aic_irq_agg_chk.sv
module aic_irq_agg_chk
    import aic_pkg::*;
#(
    parameter int NUM_IN    = 4,
    parameter int NUM_OUT   = 4,
    parameter int NUM_CODEC = 4,
    localparam int NUM_STR  = NUM_IN + NUM_OUT,
    localparam int FLD_ALL  = NUM_STR * FIELD_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [RING_W-1:0]    ring_sts,
    input logic [RING_W-1:0]    ring_ctl,
    input logic [NUM_CODEC-1:0] codec_chg,
    input logic [NUM_CODEC-1:0] codec_wake,
    input logic [FLD_ALL-1:0]   strm_sts,
    input logic [FLD_ALL-1:0]   strm_ctl,
    input logic [STS_W-1:0]     int_ctl,
    input logic [STS_W-1:0]     int_sts,
    input logic                 irq
);
    logic               ring_q;
    logic               codec_q;
    logic [NUM_STR-1:0] str_q;
    logic [STS_W-1:0]   ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q  <= 1'b0;
            codec_q <= 1'b0;
            str_q   <= '0;
            ctl_q   <= '0;
        end else begin
            ring_q  <= (ring_sts[0] & ring_ctl[0]) | (ring_sts[1] & ring_ctl[1]);
            codec_q <= (codec_chg & codec_wake) != '0;
            for (int n = 0; n < NUM_STR; n++)
                str_q[n] <= (strm_sts[n*FIELD_W +: FIELD_W] & strm_ctl[n*FIELD_W +: FIELD_W]) != '0;
            ctl_q   <= int_ctl;
        end
    end

    assert_ring_ctrl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ring_q |-> int_sts[CTRL_BIT]);

    assert_codec_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int_sts[CTRL_BIT] == (ring_q | codec_q));

    assert_stream_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int_sts[NUM_STR-1:0] == str_q);

    assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int_sts[CTRL_BIT-1:NUM_STR] == '0);

    assert_global_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int_sts[GLOBAL_BIT] == (int_sts[CTRL_BIT:0] != '0));

    assert_line_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (ctl_q[GLOBAL_BIT] && ((int_sts[CTRL_BIT:0] & ctl_q[CTRL_BIT:0]) != '0)));

    assert_global_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[CTRL_BIT:0] == '0) |-> !irq);
endmodule

bind aic_irq_agg aic_irq_agg_chk #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .NUM_CODEC(NUM_CODEC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ring_sts(ring_sts), .ring_ctl(ring_ctl),
    .codec_chg(codec_chg), .codec_wake(codec_wake), .strm_sts(strm_sts),
    .strm_ctl(strm_ctl), .int_ctl(int_ctl), .int_sts(int_sts), .irq(irq)
);

// File: tb/aic_irq_agg_test.sv
`timescale 1ns/1ps
module aic_irq_agg_test;
    localparam int NI  = 4;
    localparam int NO  = 4;
    localparam int NC  = 4;
    localparam int NS  = NI + NO;
    localparam int FA  = NS * 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    ring_sts = '0, ring_ctl = '0;
    logic [NC-1:0] codec_chg = '0, codec_wake = '0;
    logic [FA-1:0] strm_sts = '0, strm_ctl = '0;
    logic [31:0]   int_ctl = '0;
    logic [31:0]   int_sts;
    logic          irq;
    logic [NS-1:0] strm_is_in;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    aic_irq_agg #(.NUM_IN(NI), .NUM_OUT(NO), .NUM_CODEC(NC)) uut (
        .clk(clk), .rst_n(rst_n), .ring_sts(ring_sts), .ring_ctl(ring_ctl),
        .codec_chg(codec_chg), .codec_wake(codec_wake), .strm_sts(strm_sts),
        .strm_ctl(strm_ctl), .int_ctl(int_ctl), .int_sts(int_sts), .irq(irq),
        .strm_is_in(strm_is_in)
    );

    function automatic logic [31:0] exp_sts();
        logic [31:0] s = '0;
        if ((ring_sts & ring_ctl) != 2'b00) s[30] = 1'b1;   // R1
        if ((codec_chg & codec_wake) != '0) s[30] = 1'b1;   // R2
        for (int n = 0; n < NS; n++)                         // R3
            if ((strm_sts[n*3 +: 3] & strm_ctl[n*3 +: 3]) != 3'b0) s[n] = 1'b1;
        if (s[30:0] != '0) s[31] = 1'b1;                     // R4
        return s;
    endfunction

    function automatic logic exp_irq(input logic [31:0] s);
        return int_ctl[31] && ((s[30:0] & int_ctl[30:0]) != '0);  // R5
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step_check(input string req);
        logic [31:0] es;
        logic        ei;
        es = exp_sts();
        ei = exp_irq(es);
        @(posedge clk); #1;
        check({req, " status"}, int_sts, es);
        check({req, " line"}, {31'b0, irq}, {31'b0, ei});
    endtask

    task automatic clear_all();
        ring_sts = '0; ring_ctl = '0; codec_chg = '0; codec_wake = '0;
        strm_sts = '0; strm_ctl = '0; int_ctl = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_a1c0));
        // R9: reset holds outputs low even with every source active
        ring_sts = '1; ring_ctl = '1; int_ctl = '1;
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset status", int_sts, 32'h0);
        check("R9 reset line", {31'b0, irq}, 32'h0);
        clear_all();
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R7: direction map
        for (int n = 0; n < NS; n++)
            check("R7 direction", {31'b0, strm_is_in[n]}, {31'b0, (n < NI)});

        // R1: each ring bit alone, without then with its enable
        for (int b = 0; b < 2; b++) begin
            clear_all(); int_ctl = 32'hC000_0000;
            ring_sts[b] = 1'b1;
            step_check("R1 ring no-enable");
            ring_ctl[b] = 1'b1;
            step_check("R1 ring enabled");
        end

        // R2: each codec flag alone
        for (int c = 0; c < NC; c++) begin
            clear_all(); int_ctl = 32'hC000_0000;
            codec_chg[c] = 1'b1;
            step_check("R2 codec unmasked-off");
            codec_wake[c] = 1'b1;
            step_check("R2 codec woken");
        end

        // R3/R5: each stream, each field bit, enable on and off
        for (int n = 0; n < NS; n++) begin
            for (int f = 0; f < 3; f++) begin
                clear_all();
                strm_sts[n*3 + f] = 1'b1;
                strm_ctl[n*3 + f] = 1'b1;
                int_ctl[31] = 1'b1;
                step_check("R3 stream no line enable");
                int_ctl[n] = 1'b1;
                step_check("R5 stream line enabled");
                int_ctl[31] = 1'b0;
                step_check("R5 global enable off");
            end
        end

        // R6: global bit set with all enables clear
        clear_all();
        ring_sts = 2'b11; ring_ctl = 2'b11; strm_sts = '1; strm_ctl = '1;
        int_ctl = 32'h8000_0000;
        step_check("R6 global alone");
        check("R6 global bit reads 1", {31'b0, int_sts[31]}, 32'h1);

        // R8: one-cycle latency, output holds before the edge
        clear_all(); int_ctl = 32'hC000_0000;
        step_check("R8 idle");
        ring_sts = 2'b01; ring_ctl = 2'b01;
        #1;
        check("R8 no early change", int_sts, 32'h0);
        step_check("R8 after edge");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            ring_sts   = 2'($urandom);
            ring_ctl   = 2'($urandom);
            codec_chg  = NC'($urandom) & NC'($urandom);
            codec_wake = NC'($urandom);
            strm_sts   = FA'($urandom) & FA'($urandom);
            strm_ctl   = FA'($urandom) & FA'($urandom);
            int_ctl    = $urandom & $urandom;
            int_ctl[31] = ($urandom % 4) != 0;
            step_check("R1-mix R2 R3 R4 R5");
        end

        finish_run();
    end
endmodule